// File: doc/BRIEF.md
# Panel Register Setup Sequencer over SPI

This block brings a display panel into a working state by writing a fixed list of register address/data pairs to it over a write-only SPI link. A start request plays the whole list. Every entry except the last goes out back to back. The final entry, which takes the panel out of standby, is held back until a programmable settling delay has passed. The block also handles power state changes. A suspend request puts the panel into standby and then keeps the block busy for a long settle time. A resume request takes the panel out of standby and then replays the complete list.

Each register write is a single 32-bit frame sent most significant bit first. Its upper half-word carries a zero tag byte and the register address. Its lower half-word carries a tag byte of 0x01 and the data byte. The SPI clock comes from the system clock through a parameterized divider, and both delays are parameterized as system clock cycle counts. A separate level input controls the panel's active-low reset pin. The host sees a busy level and a one-cycle done pulse.

Top module: `panel_init_seq`

## Requirements
- R1: Each register write is one frame of 32 bits, shifted out MSB first: bits 31..24 = 0x00, bits 23..16 = register address, bits 15..8 = 0x01, bits 7..0 = data.
- R2: The serial clock idles low while chip select is high. MOSI changes only while the clock is low. Chip select stays low for exactly 32 rising clock edges per frame, and stays high for at least one serial clock period between frames.
- R3: A start request sends the table in this order as (address, data) pairs: (3,0x01) (0,0x00) (1,0x01) (4,0x00) (5,0x14) (6,0x24) (16,0xD7) (17,0x00) (18,0x00) (19,0x55) (20,0x01) (2,0x00).
- R4: Between the rise of chip select that ends the second-to-last table frame and the fall that begins the last one, at least INIT_WAIT_CYC system clock cycles pass.
- R5: A suspend request sends the single frame (2,0x01). Busy then stays high for at least SUSP_WAIT_CYC further cycles before done.
- R6: A resume request sends (2,0x00) first and then the full table of R3, including the R4 wait.
- R7: A start, suspend or resume request that arrives while busy is high is ignored, and this includes the cycle in which done is high.
- R8: When several requests arrive together while idle, start is taken before resume, and resume before suspend.
- R9: Done is high for exactly one cycle when a sequence completes. Busy is high in that cycle and low in the next.
- R10: The panel reset output is low after reset and then follows the display-enable input one cycle later.
- R11: After reset, chip select is high, the serial clock and MOSI are low, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request a full table write |
| suspend_i | input | 1 | Request standby entry |
| resume_i | input | 1 | Request standby exit followed by the table |
| disp_en_i | input | 1 | Display enable level that drives the panel reset pin |
| spi_sclk_o | output | 1 | Serial clock, mode 0 |
| spi_mosi_o | output | 1 | Serial data to the panel |
| spi_cs_no | output | 1 | Active-low chip select |
| panel_rst_no | output | 1 | Active-low panel reset |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse when a sequence completes |

## Verification
Two collisions are provoked. In the first, a new request lands in the very cycle that done is high. The bench raises suspend at the done cycle, then watches that busy falls on the next cycle and that no further frame appears. In the second, several requests arrive in the same idle cycle. The bench fires all three together, and then resume with suspend. It judges the winner by the first captured frame and by the total frame count.

// File: rtl/pis_pkg.sv
package pis_pkg;

  localparam int TBL_N   = 12;
  localparam int FRAME_W = 32;

  localparam logic [7:0] ADDR_TAG   = 8'h00;
  localparam logic [7:0] DATA_TAG   = 8'h01;
  localparam logic [7:0] STBY_REG   = 8'd2;
  localparam logic [7:0] STBY_ENTER = 8'h01;
  localparam logic [7:0] STBY_LEAVE = 8'h00;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
  } pis_pair_t;

  typedef enum logic [2:0] {
    C_IDLE,
    C_SEND,
    C_WAIT,
    C_HOLD,
    C_FIN
  } pis_cstate_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_SHIFT,
    TX_GAP
  } pis_tstate_e;

  function automatic logic [FRAME_W-1:0] pack_frame(input pis_pair_t p);
    return {ADDR_TAG, p.addr, DATA_TAG, p.data};
  endfunction

endpackage

// File: rtl/pis_rst_sync.sv
module pis_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  generate
    if (STAGES <= 1) begin : g_single
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
      assign rst_sn = sync_q;
    end else begin : g_chain
      logic [STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
      assign rst_sn = sync_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pis_table.sv
module pis_table
  import pis_pkg::*;
#(
  parameter int IDX_W = $clog2(TBL_N)
) (
  input  logic [IDX_W-1:0] idx_i,
  output pis_pair_t        pair_o
);

  // The final row must stay the standby-exit write: the controller
  // inserts the settling delay in front of it.
  always_comb begin
    case (int'(idx_i))
      0:       pair_o = '{addr: 8'd3,  data: 8'h01};
      1:       pair_o = '{addr: 8'd0,  data: 8'h00};
      2:       pair_o = '{addr: 8'd1,  data: 8'h01};
      3:       pair_o = '{addr: 8'd4,  data: 8'h00};
      4:       pair_o = '{addr: 8'd5,  data: 8'h14};
      5:       pair_o = '{addr: 8'd6,  data: 8'h24};
      6:       pair_o = '{addr: 8'd16, data: 8'hD7};
      7:       pair_o = '{addr: 8'd17, data: 8'h00};
      8:       pair_o = '{addr: 8'd18, data: 8'h00};
      9:       pair_o = '{addr: 8'd19, data: 8'h55};
      10:      pair_o = '{addr: 8'd20, data: 8'h01};
      default: pair_o = '{addr: STBY_REG, data: STBY_LEAVE};
    endcase
  end

endmodule

// File: rtl/pis_spi_tx.sv
module pis_spi_tx
  import pis_pkg::*;
#(
  parameter int HALF_DIV = 8
) (
  input  logic               clk,
  input  logic               rst_sn,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic               done_o,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic               cs_no
);

  localparam int GAP_CYC = 2 * HALF_DIV;
  localparam int DIV_W   = $clog2(GAP_CYC + 1);
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam logic [DIV_W-1:0] TICK_V = DIV_W'(HALF_DIV - 1);
  localparam logic [DIV_W-1:0] GAP_V  = DIV_W'(GAP_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_B = BIT_W'(FRAME_W - 1);

  pis_tstate_e        st_q, st_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               sclk_q, sclk_d;
  logic               done_q, done_d;

  always_comb begin
    st_d   = st_q;
    div_d  = div_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    sclk_d = sclk_q;
    done_d = 1'b0;
    case (st_q)
      TX_IDLE: begin
        if (start_i) begin
          st_d   = TX_SHIFT;
          sh_d   = word_i;
          div_d  = '0;
          bit_d  = '0;
          sclk_d = 1'b0;
        end
      end
      TX_SHIFT: begin
        if (div_q == TICK_V) begin
          div_d = '0;
          if (!sclk_q) begin
            sclk_d = 1'b1;
          end else begin
            sclk_d = 1'b0;
            if (bit_q == LAST_B) begin
              st_d = TX_GAP;
            end else begin
              sh_d  = {sh_q[FRAME_W-2:0], 1'b0};
              bit_d = bit_q + 1'b1;
            end
          end
        end else begin
          div_d = div_q + 1'b1;
        end
      end
      TX_GAP: begin
        if (div_q == GAP_V) begin
          st_d   = TX_IDLE;
          div_d  = '0;
          done_d = 1'b1;
        end else begin
          div_d = div_q + 1'b1;
        end
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= TX_IDLE;
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = (st_q == TX_SHIFT) ? sh_q[FRAME_W-1] : 1'b0;
  assign cs_no  = (st_q != TX_SHIFT);
  assign done_o = done_q;

endmodule

// File: rtl/pis_ctrl.sv
module pis_ctrl
  import pis_pkg::*;
#(
  parameter int INIT_WAIT_CYC = 5000,
  parameter int SUSP_WAIT_CYC = 10_000_000,
  parameter int IDX_W         = $clog2(TBL_N)
) (
  input  logic               clk,
  input  logic               rst_sn,
  input  logic               start_i,
  input  logic               suspend_i,
  input  logic               resume_i,
  input  logic               tx_done_i,
  input  pis_pair_t          tbl_pair_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               tx_start_o,
  output logic [FRAME_W-1:0] tx_word_o,
  output logic               busy_o,
  output logic               done_o
);

  localparam int WAIT_MAX = (INIT_WAIT_CYC > SUSP_WAIT_CYC) ? INIT_WAIT_CYC : SUSP_WAIT_CYC;
  localparam int CNT_W    = $clog2(WAIT_MAX + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TBL_N - 1);
  localparam logic [IDX_W-1:0] PENU_IDX = IDX_W'(TBL_N - 2);
  localparam logic [CNT_W-1:0] INIT_LD  = CNT_W'(INIT_WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] SUSP_LD  = CNT_W'(SUSP_WAIT_CYC - 1);

  pis_cstate_e      st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             susp_q, susp_d;   // current sequence is a standby entry
  logic             pre_q, pre_d;     // standby-exit frame pending before table
  pis_pair_t        sel_pair;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    susp_d = susp_q;
    pre_d  = pre_q;
    case (st_q)
      C_IDLE: begin
        // fixed priority: start, then resume, then suspend
        if (start_i) begin
          st_d = C_SEND; susp_d = 1'b0; pre_d = 1'b0; idx_d = '0;
        end else if (resume_i) begin
          st_d = C_SEND; susp_d = 1'b0; pre_d = 1'b1; idx_d = '0;
        end else if (suspend_i) begin
          st_d = C_SEND; susp_d = 1'b1; pre_d = 1'b0; idx_d = '0;
        end
      end
      C_SEND: st_d = C_WAIT;
      C_WAIT: begin
        if (tx_done_i) begin
          if (susp_q) begin
            st_d  = C_HOLD;
            cnt_d = SUSP_LD;
          end else if (pre_q) begin
            pre_d = 1'b0;
            st_d  = C_SEND;
          end else if (idx_q == LAST_IDX) begin
            st_d = C_FIN;
          end else begin
            idx_d = idx_q + 1'b1;
            if (idx_q == PENU_IDX) begin
              st_d  = C_HOLD;
              cnt_d = INIT_LD;
            end else begin
              st_d = C_SEND;
            end
          end
        end
      end
      C_HOLD: begin
        if (cnt_q == '0) st_d = susp_q ? C_FIN : C_SEND;
        else             cnt_d = cnt_q - 1'b1;
      end
      C_FIN:   st_d = C_IDLE;
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= C_IDLE;
      idx_q  <= '0;
      cnt_q  <= '0;
      susp_q <= 1'b0;
      pre_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      susp_q <= susp_d;
      pre_q  <= pre_d;
    end
  end

  always_comb begin
    if (susp_q)     sel_pair = '{addr: STBY_REG, data: STBY_ENTER};
    else if (pre_q) sel_pair = '{addr: STBY_REG, data: STBY_LEAVE};
    else            sel_pair = tbl_pair_i;
  end

  assign tx_word_o  = pack_frame(sel_pair);
  assign tx_start_o = (st_q == C_SEND);
  assign idx_o      = idx_q;
  assign busy_o     = (st_q != C_IDLE);
  assign done_o     = (st_q == C_FIN);

endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
  import pis_pkg::*;
#(
  parameter int SCLK_HALF_DIV   = 8,
  parameter int INIT_WAIT_CYC   = 5000,
  parameter int SUSP_WAIT_CYC   = 10_000_000,
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic suspend_i,
  input  logic resume_i,
  input  logic disp_en_i,
  output logic spi_sclk_o,
  output logic spi_mosi_o,
  output logic spi_cs_no,
  output logic panel_rst_no,
  output logic busy_o,
  output logic done_o
);

  localparam int IDX_W = $clog2(TBL_N);

  logic               rst_sn;
  logic [IDX_W-1:0]   idx;
  pis_pair_t          pair;
  logic               tx_start;
  logic               tx_done;
  logic [FRAME_W-1:0] tx_word;
  logic               prst_q;

  pis_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  pis_table #(.IDX_W(IDX_W)) u_tbl (
    .idx_i  (idx),
    .pair_o (pair)
  );

  pis_ctrl #(
    .INIT_WAIT_CYC (INIT_WAIT_CYC),
    .SUSP_WAIT_CYC (SUSP_WAIT_CYC),
    .IDX_W         (IDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .start_i    (start_i),
    .suspend_i  (suspend_i),
    .resume_i   (resume_i),
    .tx_done_i  (tx_done),
    .tbl_pair_i (pair),
    .idx_o      (idx),
    .tx_start_o (tx_start),
    .tx_word_o  (tx_word),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  pis_spi_tx #(.HALF_DIV(SCLK_HALF_DIV)) u_tx (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .start_i (tx_start),
    .word_i  (tx_word),
    .done_o  (tx_done),
    .sclk_o  (spi_sclk_o),
    .mosi_o  (spi_mosi_o),
    .cs_no   (spi_cs_no)
  );

  // panel reset pin follows the display-enable level, low out of reset
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) prst_q <= 1'b0;
    else         prst_q <= disp_en_i;
  end
  assign panel_rst_no = prst_q;

endmodule

// File: rtl/pis_chk.sv
module pis_chk (
  input logic clk,
  input logic rst_sn,
  input logic start_i,
  input logic suspend_i,
  input logic resume_i,
  input logic disp_en_i,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic prst_n,
  input logic busy,
  input logic done
);

  logic       sclk_d;
  logic [6:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_d <= sclk;
      if (cs_n)               rise_cnt <= '0;
      else if (sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  a_r2_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_sn)
    cs_n |-> !sclk);

  a_r2_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_sn)
    (sclk && $past(sclk)) |-> $stable(mosi));

  a_r2_frame_32_edges: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(cs_n) |-> (rise_cnt == 7'd32));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done);

  a_r9_done_with_busy: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> busy);

  a_r7_busy_from_request: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(busy) |-> $past(start_i || suspend_i || resume_i));

  a_r10_reset_pin_follows: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(rst_sn) |-> (prst_n == $past(disp_en_i)));

endmodule

bind panel_init_seq pis_chk u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .start_i   (start_i),
  .suspend_i (suspend_i),
  .resume_i  (resume_i),
  .disp_en_i (disp_en_i),
  .sclk      (spi_sclk_o),
  .mosi      (spi_mosi_o),
  .cs_n      (spi_cs_no),
  .prst_n    (panel_rst_no),
  .busy      (busy_o),
  .done      (done_o)
);

// File: tb/panel_init_seq_tb_top.sv
`timescale 1ns/1ps
module panel_init_seq_tb_top;

  localparam int HALF  = 2;
  localparam int IWAIT = 40;
  localparam int SWAIT = 300;
  localparam int NTBL  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, suspend_i = 1'b0, resume_i = 1'b0, disp_en_i = 1'b0;
  logic sclk, mosi, cs_n, prst_n, busy, done;

  always #2 clk = ~clk;

  panel_init_seq #(
    .SCLK_HALF_DIV (HALF),
    .INIT_WAIT_CYC (IWAIT),
    .SUSP_WAIT_CYC (SWAIT),
    .RST_SYNC_STAGES (2)
  ) dut_i (
    .clk (clk), .rst_n (rst_n),
    .start_i (start_i), .suspend_i (suspend_i), .resume_i (resume_i),
    .disp_en_i (disp_en_i),
    .spi_sclk_o (sclk), .spi_mosi_o (mosi), .spi_cs_no (cs_n),
    .panel_rst_no (prst_n), .busy_o (busy), .done_o (done)
  );

  int n_chk = 0, n_bad = 0;
  int ncyc = 0;
  int nfr = 0;
  int nbits = 0;
  logic [31:0] shreg = '0;
  logic [31:0] fr [0:63];
  int fbits [0:63];
  int fall_t [0:63];
  int rise_t [0:63];
  bit finished = 0;

  always @(posedge clk) ncyc <= ncyc + 1;

  always @(negedge cs_n) begin
    if (nfr < 64) fall_t[nfr] = ncyc;
    nbits = 0;
    shreg = '0;
  end
  always @(posedge sclk) if (!cs_n) begin
    shreg = {shreg[30:0], mosi};
    nbits = nbits + 1;
  end
  always @(posedge cs_n) if (nfr < 64) begin
    fr[nfr] = shreg; fbits[nfr] = nbits; rise_t[nfr] = ncyc; nfr = nfr + 1;
  end

  function automatic logic [15:0] exp_pair(int i);
    case (i)
      0: return {8'd3, 8'h01};   1: return {8'd0, 8'h00};
      2: return {8'd1, 8'h01};   3: return {8'd4, 8'h00};
      4: return {8'd5, 8'h14};   5: return {8'd6, 8'h24};
      6: return {8'd16, 8'hD7};  7: return {8'd17, 8'h00};
      8: return {8'd18, 8'h00};  9: return {8'd19, 8'h55};
      10: return {8'd20, 8'h01};
      default: return {8'd2, 8'h00};
    endcase
  endfunction

  function automatic logic [31:0] exp_frame(logic [7:0] a, logic [7:0] d);
    return {8'h00, a, 8'h01, d};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic pulse(bit s, bit su, bit re);
    @(negedge clk);
    start_i = s; suspend_i = su; resume_i = re;
    @(negedge clk);
    start_i = 0; suspend_i = 0; resume_i = 0;
  endtask

  task automatic wait_idle(output int dcnt, output int cyc, output bit late_busy);
    dcnt = 0; cyc = 0; late_busy = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (done) dcnt++;
    end while (busy && cyc < 20000);
    late_busy = busy;
  endtask

  task automatic check_table(int base, string req);
    for (int i = 0; i < NTBL; i++) begin
      logic [15:0] p;
      p = exp_pair(i);
      chk(fr[base+i] == exp_frame(p[15:8], p[7:0]), req, fr[base+i], exp_frame(p[15:8], p[7:0]));
      chk(fbits[base+i] == 32, "R2 bits per frame", fbits[base+i], 32);
    end
    chk(fall_t[base+NTBL-1] - rise_t[base+NTBL-2] >= IWAIT, "R4 settle wait",
        fall_t[base+NTBL-1] - rise_t[base+NTBL-2], IWAIT);
    chk(fall_t[base+1] - rise_t[base] >= 2*HALF, "R2 frame gap",
        fall_t[base+1] - rise_t[base], 2*HALF);
  endtask

  task automatic run_cmd(int kind);
    int dc, cy; bit lb;
    nfr = 0;
    if (kind == 0) pulse(1, 0, 0);
    else if (kind == 1) pulse(0, 1, 0);
    else pulse(0, 0, 1);
    wait_idle(dc, cy, lb);
    chk(dc == 1, "R9 done pulse count", dc, 1);
    chk(!lb, "R9 busy low after done", lb, 0);
    if (kind == 0) begin
      chk(nfr == NTBL, "R3 frame count", nfr, NTBL);
      check_table(0, "R3 init frame");
    end else if (kind == 1) begin
      chk(nfr == 1, "R5 frame count", nfr, 1);
      chk(fr[0] == exp_frame(8'd2, 8'h01), "R5 standby frame", fr[0], exp_frame(8'd2, 8'h01));
      chk(fbits[0] == 32, "R1 frame width", fbits[0], 32);
      chk(cy >= SWAIT + 64*HALF, "R5 hold time", cy, SWAIT + 64*HALF);
    end else begin
      chk(nfr == NTBL + 1, "R6 frame count", nfr, NTBL + 1);
      chk(fr[0] == exp_frame(8'd2, 8'h00), "R6 wake frame", fr[0], exp_frame(8'd2, 8'h00));
      check_table(1, "R6 replay frame");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int dc, cy; bit lb;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);
    nfr = 0;
    // R11 reset state
    chk(cs_n == 1, "R11 cs_n", cs_n, 1);
    chk(sclk == 0 && mosi == 0, "R11 sclk/mosi", {sclk, mosi}, 0);
    chk(busy == 0 && done == 0, "R11 busy/done", {busy, done}, 0);
    chk(prst_n == 0, "R10 reset pin after reset", prst_n, 0);

    // R1 R3 R4 plain start
    run_cmd(0);
    // R5 suspend, R6 resume
    run_cmd(1);
    run_cmd(2);

    // R7 requests while busy are ignored
    nfr = 0;
    pulse(1, 0, 0);
    repeat (200) @(negedge clk);
    pulse(0, 1, 1);
    pulse(1, 0, 0);
    wait_idle(dc, cy, lb);
    chk(nfr == NTBL, "R7 busy requests ignored", nfr, NTBL);
    check_table(0, "R7 table intact");

    // R7 request in the done cycle
    nfr = 0;
    pulse(1, 0, 0);
    cy = 0;
    while (!done && cy < 20000) begin @(negedge clk); cy++; end
    suspend_i = 1;
    @(negedge clk);
    suspend_i = 0;
    chk(busy == 0, "R7 done-cycle request busy", busy, 0);
    repeat (30) @(negedge clk);
    chk(busy == 0 && nfr == NTBL, "R7 done-cycle request ignored", nfr, NTBL);

    // R8 priority
    nfr = 0;
    pulse(1, 1, 1);
    wait_idle(dc, cy, lb);
    chk(nfr == NTBL, "R8 start wins count", nfr, NTBL);
    chk(fr[0] == exp_frame(8'd3, 8'h01), "R8 start wins frame", fr[0], exp_frame(8'd3, 8'h01));
    nfr = 0;
    pulse(0, 1, 1);
    wait_idle(dc, cy, lb);
    chk(nfr == NTBL + 1, "R8 resume beats suspend", nfr, NTBL + 1);
    chk(fr[0] == exp_frame(8'd2, 8'h00), "R8 resume first frame", fr[0], exp_frame(8'd2, 8'h00));

    // R10 reset pin directed
    @(negedge clk); disp_en_i = 1;
    @(negedge clk);
    chk(prst_n == 1, "R10 reset pin high", prst_n, 1);
    disp_en_i = 0;
    @(negedge clk);
    chk(prst_n == 0, "R10 reset pin low", prst_n, 0);

    // random mix
    for (int it = 0; it < 6; it++) begin
      int k;
      bit e;
      k = $urandom % 3;
      e = $urandom % 2;
      @(negedge clk); disp_en_i = e;
      @(negedge clk);
      chk(prst_n == e, "R10 random enable", prst_n, e);
      run_cmd(k);
    end

    finish_run();
  end

endmodule